// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. It oversamples the line 32 times per bit period, so one bit lasts 32 × divider clock cycles. A start bit counts only if the line still reads low at the middle of that bit. Each data bit is then sampled at the centre of its period. The character format is set at run time: five to eight data bits, then an optional parity bit that is even, odd or a fixed value, then a stop bit.

Each received character goes into a four-entry queue together with its own parity-error, framing-error and break flags. The host drains the queue through a valid/ready stream. The block also reports, at its ports, that data is waiting, that the queue is full, that a character was lost to overrun, and when a break starts and ends. It can lower its ready-to-send output to hold off the far end while the queue is full.

A two-bit channel mode chooses how the line is routed. The modes are normal operation, echo of the received line onto the transmit pin, internal loopback of the local transmitter into the receiver, and remote loopback. In remote loopback the received line is echoed and nothing reaches the host.

Top module: `serial_rx_channel`

## Requirements
- R1: A falling edge on the line starts a character only if the line is still low when it is sampled half a bit period later. A low pulse shorter than that yields no character.
- R2: `cfg_data_len` selects 5 + its value data bits (0 selects 5, 3 selects 8). The bits are taken least significant first and are sampled once per 32 × `cfg_baud_div` clocks. Unused upper bits of `rd_data` read zero. A divider value of 0 acts as 1.
- R3: `cfg_parity` selects the parity check: 0 none, 1 even, 2 odd, 3 fixed (the bit must equal `cfg_force_par`). A parity bit that does not match sets `rd_par_err` on that entry only.
- R4: A character whose stop bit samples low, and which has at least one high bit, is stored with `rd_frm_err` set and its data kept.
- R5: A character whose start, data, parity and stop samples are all low is stored as a break entry: `rd_brk`=1, data 0, other flags 0. It also raises a one-cycle `brk_start`. When the line is next seen high, a one-cycle `brk_end` follows. If a break begins partway through a character, that character is stored with a framing error and the break entry follows it.
- R6: The queue holds four entries in arrival order. `rx_rdy` is high while at least one entry waits, and `fifo_full` is high while four wait.
- R7: A character that completes while the queue is full and no entry is taken in that cycle is discarded, and `overrun` pulses for one cycle. The stored entries are kept. If an entry is taken in the same cycle, the new character is stored and no overrun is reported.
- R8: Once `rd_valid` is high, it stays high and the entry (`rd_data`, `rd_par_err`, `rd_frm_err`, `rd_brk`) stays unchanged until a cycle with `rd_ready` high takes it.
- R9: With `cfg_rts_auto`=1, `rts_o` is low while the queue is full and high otherwise. With `cfg_rts_auto`=0, `rts_o` is high.
- R10: `cfg_chan_mode` selects the routing. 0, normal: the receiver reads `rx_line` and `tx_line` follows `tx_from_xmit`. 1, echo: the receiver reads `rx_line` and `tx_line` follows `rx_line`. 2, local loopback: the receiver reads `tx_from_xmit`, `rx_line` is ignored and `tx_line` is held at 1. 3, remote loopback: `tx_line` follows `rx_line` and no character is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_baud_div | input | 16 | Divider; a bit lasts 32 × divider clocks |
| cfg_data_len | input | 2 | Data length code, 5 + value bits |
| cfg_parity | input | 2 | Parity mode: none, even, odd, fixed |
| cfg_force_par | input | 1 | Value the parity bit must have in fixed mode |
| cfg_chan_mode | input | 2 | Channel routing mode |
| cfg_rts_auto | input | 1 | Drive `rts_o` from queue occupancy |
| rx_line | input | 1 | Serial receive line |
| tx_from_xmit | input | 1 | Serial output of the companion transmitter |
| tx_line | output | 1 | Serial transmit pin |
| rd_valid | output | 1 | An entry is offered |
| rd_ready | input | 1 | The consumer takes the offered entry |
| rd_data | output | 8 | Received data of the offered entry |
| rd_par_err | output | 1 | Parity error of the offered entry |
| rd_frm_err | output | 1 | Framing error of the offered entry |
| rd_brk | output | 1 | The offered entry is a break |
| rx_rdy | output | 1 | At least one entry waits |
| fifo_full | output | 1 | Four entries wait |
| overrun | output | 1 | One-cycle pulse: a character was lost |
| brk_start | output | 1 | One-cycle pulse: a break was detected |
| brk_end | output | 1 | One-cycle pulse: the line returned high after a break |
| rts_o | output | 1 | Ready-to-send to the far end |

## Verification
A character can complete in the same cycle as the consumer takes an entry from a full queue. In that cycle the store must be accepted and no overrun reported. The bench fills the queue with `rd_ready` held low, then sends a further character. It raises `rd_ready` for a single cycle, timed from the bit count to land on the cycle the new character is written. The result is judged by the overrun pulse count staying unchanged and by the scoreboard seeing the oldest entry leave first and the new character arrive last. A companion case, with no entry taken, must report exactly one overrun and keep the four stored characters.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_ECHO   = 2'd1,
    MODE_LOCAL  = 2'd2,
    MODE_REMOTE = 2'd3
  } chan_mode_e;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_FIXED = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRKWAIT
  } rx_state_e;

  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rx_entry_t;
endpackage

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? '0 : div - 1'b1;
  assign tick = (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/srx_frame_engine.sv
module srx_frame_engine
  import srx_pkg::*;
#(
  parameter int PHASES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line,
  input  logic       tick,
  input  logic [1:0] data_len,
  input  logic [1:0] par_mode,
  input  logic       force_val,
  output logic       restart,
  output logic       done,
  output rx_entry_t  entry,
  output logic       brk_start,
  output logic       brk_end
);
  localparam int PH_W = $clog2(PHASES);
  localparam logic [PH_W-1:0] MID = PH_W'(PHASES / 2 - 1);

  rx_state_e       state;
  logic [PH_W-1:0] phase;
  logic [2:0]      bit_idx;
  logic [7:0]      shreg;
  logic            par_acc;
  logic            par_bit;
  logic            allz;
  logic            sample_now;
  logic            framing;
  logic [2:0]      last_idx;
  logic            par_err;

  assign framing    = (state == ST_START) || (state == ST_DATA) ||
                      (state == ST_PAR)   || (state == ST_STOP);
  assign sample_now = framing && tick && (phase == MID);
  assign last_idx   = 3'd4 + {1'b0, data_len};
  assign restart    = (state == ST_IDLE) && !line;

  always_comb begin
    case (par_mode_e'(par_mode))
      PAR_EVEN:  par_err = par_acc ^ par_bit;
      PAR_ODD:   par_err = !(par_acc ^ par_bit);
      PAR_FIXED: par_err = (par_bit != force_val);
      default:   par_err = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phase     <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      par_acc   <= 1'b0;
      par_bit   <= 1'b0;
      allz      <= 1'b1;
      done      <= 1'b0;
      entry     <= '0;
      brk_start <= 1'b0;
      brk_end   <= 1'b0;
    end else begin
      done      <= 1'b0;
      brk_start <= 1'b0;
      brk_end   <= 1'b0;
      if (framing && tick) phase <= phase + 1'b1;
      case (state)
        ST_IDLE: begin
          if (!line) begin
            state   <= ST_START;
            phase   <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            par_bit <= 1'b0;
            allz    <= 1'b1;
          end
        end
        ST_START: begin
          if (sample_now) state <= line ? ST_IDLE : ST_DATA;
        end
        ST_DATA: begin
          if (sample_now) begin
            shreg[bit_idx] <= line;
            par_acc        <= par_acc ^ line;
            if (line) allz <= 1'b0;
            if (bit_idx == last_idx)
              state <= (par_mode_e'(par_mode) == PAR_NONE) ? ST_STOP : ST_PAR;
            else
              bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_PAR: begin
          if (sample_now) begin
            par_bit <= line;
            if (line) allz <= 1'b0;
            state <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (sample_now) begin
            done <= 1'b1;
            if (!line && allz) begin
              entry     <= '{brk: 1'b1, frm: 1'b0, par: 1'b0, data: 8'h00};
              brk_start <= 1'b1;
              state     <= ST_BRKWAIT;
            end else begin
              entry <= '{brk: 1'b0, frm: !line, par: par_err, data: shreg};
              state <= ST_IDLE;
            end
          end
        end
        ST_BRKWAIT: begin
          if (line) begin
            brk_end <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         ovr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_pop;
  logic             accept;

  assign empty  = (count == '0);
  assign full   = (count == FULLC);
  assign do_pop = pop && !empty;
  assign accept = push && (!full || do_pop);
  assign head   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr    <= 1'b0;
    end else begin
      ovr <= push && !accept;
      if (accept) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({accept, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_channel.sv
module serial_rx_channel
  import srx_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int OVERSAMPLE = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_baud_div,
  input  logic [1:0]       cfg_data_len,
  input  logic [1:0]       cfg_parity,
  input  logic             cfg_force_par,
  input  logic [1:0]       cfg_chan_mode,
  input  logic             cfg_rts_auto,
  input  logic             rx_line,
  input  logic             tx_from_xmit,
  output logic             tx_line,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             rd_par_err,
  output logic             rd_frm_err,
  output logic             rd_brk,
  output logic             rx_rdy,
  output logic             fifo_full,
  output logic             overrun,
  output logic             brk_start,
  output logic             brk_end,
  output logic             rts_o
);
  localparam int EW = $bits(rx_entry_t);

  chan_mode_e           mode;
  logic                 line_sel;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                 line_s;
  logic                 restart;
  logic                 tick;
  logic                 done;
  rx_entry_t            new_entry;
  rx_entry_t            head_entry;
  logic [EW-1:0]        head_bits;
  logic                 empty;
  logic                 push;

  assign mode = chan_mode_e'(cfg_chan_mode);

  always_comb begin
    case (mode)
      MODE_ECHO:   begin line_sel = rx_line;      tx_line = rx_line;      end
      MODE_LOCAL:  begin line_sel = tx_from_xmit; tx_line = 1'b1;         end
      MODE_REMOTE: begin line_sel = rx_line;      tx_line = rx_line;      end
      default:     begin line_sel = rx_line;      tx_line = tx_from_xmit; end
    endcase
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= line_sel;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_sel};
      end
    end
  endgenerate
  assign line_s = sync_q[SYNC_STAGES-1];

  srx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .div     (cfg_baud_div),
    .tick    (tick)
  );

  srx_frame_engine #(.PHASES(OVERSAMPLE)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .line      (line_s),
    .tick      (tick),
    .data_len  (cfg_data_len),
    .par_mode  (cfg_parity),
    .force_val (cfg_force_par),
    .restart   (restart),
    .done      (done),
    .entry     (new_entry),
    .brk_start (brk_start),
    .brk_end   (brk_end)
  );

  assign push = done && (mode != MODE_REMOTE);

  srx_fifo #(.DEPTH(FIFO_DEPTH), .W(EW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (new_entry),
    .pop       (rd_valid && rd_ready),
    .head      (head_bits),
    .empty     (empty),
    .full      (fifo_full),
    .ovr       (overrun)
  );

  assign head_entry = rx_entry_t'(head_bits);
  assign rd_valid   = !empty;
  assign rx_rdy     = !empty;
  assign rd_data    = head_entry.data;
  assign rd_par_err = head_entry.par;
  assign rd_frm_err = head_entry.frm;
  assign rd_brk     = head_entry.brk;
  assign rts_o      = !(cfg_rts_auto && fifo_full);
endmodule

// File: rtl/serial_rx_channel_chk.sv
module serial_rx_channel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_chan_mode,
  input logic       cfg_rts_auto,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       rd_par_err,
  input logic       rd_frm_err,
  input logic       rd_brk,
  input logic       rx_rdy,
  input logic       fifo_full,
  input logic       overrun,
  input logic       brk_start,
  input logic       brk_end,
  input logic       rts_o
);
  p_full_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> rx_rdy);

  p_hold_until_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_par_err)
                                 && $stable(rd_frm_err) && $stable(rd_brk)));

  p_overrun_needs_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(fifo_full));

  p_rts_drops_on_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fifo_full) && cfg_rts_auto) |-> !rts_o);

  p_remote_no_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chan_mode == 2'd3 && !rx_rdy) |=> !rx_rdy);

  p_brk_edges_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |=> !brk_end);
endmodule

bind serial_rx_channel serial_rx_channel_chk i_chk (.*);

// File: tb/test_serial_rx_channel.sv
module test_serial_rx_channel;
  localparam int DIV = 2;
  localparam int BIT = 32 * DIV;

  typedef struct {
    logic [10:0] v;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg_baud_div = 16'(DIV);
  logic [1:0] cfg_data_len = 2'd3;
  logic [1:0] cfg_parity = 2'd0;
  logic cfg_force_par = 1'b0;
  logic [1:0] cfg_chan_mode = 2'd0;
  logic cfg_rts_auto = 1'b1;
  logic rx_line = 1'b1;
  logic tx_from_xmit = 1'b1;
  logic rd_ready = 1'b1;
  logic tx_line, rd_valid, rd_par_err, rd_frm_err, rd_brk;
  logic rx_rdy, fifo_full, overrun, brk_start, brk_end, rts_o;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  int ovr_cnt = 0;
  int bs_cnt = 0;
  int be_cnt = 0;
  exp_t sb[$];

  always #5 clk = ~clk;

  serial_rx_channel i_serial_rx_channel (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare delivered entries against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (overrun)   ovr_cnt++;
      if (brk_start) bs_cnt++;
      if (brk_end)   be_cnt++;
      if (rd_valid && rd_ready) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R10", "unexpected entry", {rd_brk, rd_frm_err, rd_par_err, rd_data}, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk({rd_brk, rd_frm_err, rd_par_err, rd_data} == e.v, e.tag, "entry",
              {rd_brk, rd_frm_err, rd_par_err, rd_data}, e.v);
        end
      end
    end
  end

  task automatic drive_bit(input bit v, input bit via_xmit);
    if (via_xmit) tx_from_xmit = v; else rx_line = v;
    repeat (BIT) @(negedge clk);
  endtask

  // sends one frame; format comes from the current configuration inputs
  task automatic send(input logic [7:0] d, input bit badpar, input bit stopv,
                      input bit via_xmit, input bit expect_it, input string tag);
    int nb;
    logic [7:0] md;
    logic pb;
    exp_t e;
    nb = 5 + int'(cfg_data_len);
    md = d & 8'((1 << nb) - 1);
    case (cfg_parity)
      2'd1:    pb = ^md;
      2'd2:    pb = ~^md;
      2'd3:    pb = cfg_force_par;
      default: pb = 1'b0;
    endcase
    pb = pb ^ badpar;
    if (expect_it) begin
      e.v = {1'b0, (stopv == 1'b0), (badpar && cfg_parity != 2'd0), md};
      e.tag = tag;
      sb.push_back(e);
    end
    @(negedge clk);
    drive_bit(1'b0, via_xmit);
    for (int i = 0; i < nb; i++) drive_bit(md[i], via_xmit);
    if (cfg_parity != 2'd0) drive_bit(pb, via_xmit);
    drive_bit(stopv, via_xmit);
    drive_bit(1'b1, via_xmit);
  endtask

  task automatic finish_sim();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_sim();
  end

  initial begin
    exp_t e;
    int ov0;
    repeat (5) @(negedge clk);
    // reset state
    chk(rx_rdy == 1'b0, "R6", "reset rx_rdy", rx_rdy, 0);
    chk(fifo_full == 1'b0, "R6", "reset fifo_full", fifo_full, 0);
    chk(tx_line == 1'b1, "R10", "reset tx_line", tx_line, 1);
    chk(rts_o == 1'b1, "R9", "reset rts_o", rts_o, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2: plain 8-bit characters
    send(8'hA5, 0, 1, 0, 1, "R2");
    send(8'h3E, 0, 1, 0, 1, "R2");
    // R1: short glitch gives nothing
    rx_line = 1'b0;
    repeat (BIT / 2 - 12) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    chk(rx_rdy == 1'b0 && sb.size() == 0, "R1", "glitch produced data", rx_rdy, 0);

    // R3: parity modes and lengths
    cfg_data_len = 2'd2; cfg_parity = 2'd1;
    send(8'h55, 0, 1, 0, 1, "R3");
    cfg_data_len = 2'd0; cfg_parity = 2'd2;
    send(8'h13, 1, 1, 0, 1, "R3");
    cfg_data_len = 2'd1; cfg_parity = 2'd3; cfg_force_par = 1'b1;
    send(8'h2A, 1, 1, 0, 1, "R3");
    cfg_data_len = 2'd3; cfg_parity = 2'd2;
    send(8'hF0, 0, 1, 0, 1, "R3");
    cfg_data_len = 2'd0; cfg_parity = 2'd0;
    send(8'hFF, 0, 1, 0, 1, "R2");
    cfg_data_len = 2'd3;

    // R4: framing error
    send(8'h3C, 0, 0, 0, 1, "R4");
    repeat (2 * BIT) @(negedge clk);

    // R6/R9: fill the queue
    rd_ready = 1'b0;
    send(8'h11, 0, 1, 0, 1, "R6");
    send(8'h22, 0, 1, 0, 1, "R6");
    send(8'h33, 0, 1, 0, 1, "R6");
    chk(fifo_full == 1'b0 && rx_rdy == 1'b1, "R6", "three stored", fifo_full, 0);
    send(8'h44, 0, 1, 0, 1, "R6");
    chk(fifo_full == 1'b1, "R6", "full after four", fifo_full, 1);
    chk(rts_o == 1'b0, "R9", "rts low when full", rts_o, 0);
    cfg_rts_auto = 1'b0;
    @(negedge clk);
    chk(rts_o == 1'b1, "R9", "rts high when auto off", rts_o, 1);
    cfg_rts_auto = 1'b1;
    // R7: overrun drops the new character
    ov0 = ovr_cnt;
    send(8'h55, 0, 1, 0, 0, "R7");
    chk(ovr_cnt == ov0 + 1, "R7", "overrun pulses", ovr_cnt - ov0, 1);
    chk(fifo_full == 1'b1, "R7", "still full", fifo_full, 1);
    // R7: completion while one entry is taken in the same cycle
    ov0 = ovr_cnt;
    fork
      send(8'h66, 0, 1, 0, 1, "R7");
      begin
        repeat (612) @(negedge clk);
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
      end
    join
    chk(ovr_cnt == ov0, "R7", "no overrun with same-cycle take", ovr_cnt - ov0, 0);
    chk(fifo_full == 1'b1, "R7", "full again", fifo_full, 1);
    rd_ready = 1'b1;
    repeat (10) @(negedge clk);
    chk(rx_rdy == 1'b0 && rts_o == 1'b1, "R9", "drained, rts high", rts_o, 1);

    // R5: whole-character break
    sb.push_back('{v: 11'h400, tag: "R5"});
    ov0 = bs_cnt;
    rx_line = 1'b0;
    repeat (12 * BIT) @(negedge clk);
    chk(bs_cnt == ov0 + 1, "R5", "break start pulse", bs_cnt - ov0, 1);
    ov0 = be_cnt;
    rx_line = 1'b1;
    repeat (BIT) @(negedge clk);
    chk(be_cnt == ov0 + 1, "R5", "break end pulse", be_cnt - ov0, 1);
    // R5: break starting mid-character
    e.v = 11'h207; e.tag = "R5";
    sb.push_back(e);
    sb.push_back('{v: 11'h400, tag: "R5"});
    ov0 = bs_cnt;
    drive_bit(1'b0, 0);
    drive_bit(1'b1, 0); drive_bit(1'b1, 0); drive_bit(1'b1, 0);
    rx_line = 1'b0;
    repeat (20 * BIT) @(negedge clk);
    rx_line = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    chk(bs_cnt == ov0 + 1, "R5", "mid-character break start", bs_cnt - ov0, 1);

    // R10: echo
    cfg_chan_mode = 2'd1;
    rx_line = 1'b0; #1;
    chk(tx_line == 1'b0, "R10", "echo low", tx_line, 0);
    rx_line = 1'b1; #1;
    chk(tx_line == 1'b1, "R10", "echo high", tx_line, 1);
    repeat (BIT) @(negedge clk);
    send(8'h9C, 0, 1, 0, 1, "R10");
    // R10: remote loopback
    cfg_chan_mode = 2'd3;
    rx_line = 1'b0; #1;
    chk(tx_line == 1'b0, "R10", "remote echo low", tx_line, 0);
    rx_line = 1'b1;
    repeat (BIT) @(negedge clk);
    send(8'h5A, 0, 1, 0, 0, "R10");
    chk(rx_rdy == 1'b0, "R10", "remote stores nothing", rx_rdy, 0);
    // R10: local loopback, rx_line ignored
    cfg_chan_mode = 2'd2;
    repeat (4) @(negedge clk);
    rx_line = 1'b0;
    tx_from_xmit = 1'b0; #1;
    chk(tx_line == 1'b1, "R10", "local tx idle", tx_line, 1);
    tx_from_xmit = 1'b1;
    repeat (BIT) @(negedge clk);
    send(8'h81, 0, 1, 1, 1, "R10");
    rx_line = 1'b1;
    repeat (BIT) @(negedge clk);
    cfg_chan_mode = 2'd0;
    // R10: normal mode passes the transmitter through
    tx_from_xmit = 1'b0; #1;
    chk(tx_line == 1'b0, "R10", "normal tx follows xmit", tx_line, 0);
    tx_from_xmit = 1'b1;
    repeat (2 * BIT) @(negedge clk);

    chk(sb.size() == 0, "R6", "scoreboard empty", sb.size(), 0);
    finish_sim();
  end
endmodule